// File: doc/BRIEF.md
# Latched Multiplexed Seven-Segment Scanner

This block drives a time-multiplexed seven-segment display from a row of BCD digits produced by a counter elsewhere on the chip. It keeps a copy of the digits in a hold register that a latch-enable input controls. While latch enable is high the copy follows the live digits; while it is low the copy keeps its value. A display-select input picks what is shown: the live digits or the held copy.

The scan runs from a free-running timebase inside the block, made by dividing the system clock with a prescaler. No separate scan clock is needed. Each digit slot begins with one prescaler tick of darkness and then shows one digit for a set number of ticks. The strobes step from the least significant digit to the most significant and then wrap. Segments and strobes are active high. A BCD value above nine shows as an unlit digit.

Top module: `seg_scan_top`

## Requirements
- R1: While `latch_en` is high, the held copy follows `digits_in`. With `show_live` low, the digit shown is the current value of `digits_in`.
- R2: While `latch_en` is low, the held copy keeps the value it had at the last clock edge where `latch_en` was high. With `show_live` low, that held value is shown, whatever `digits_in` does.
- R3: While `show_live` is high, the digit shown comes from `digits_in`, whatever the held copy contains.
- R4: At most one bit of `strobe_out` is high at any time.
- R5: After reset each digit slot lasts (DWELL_TICKS+1)*PRESCALE clocks. Slot k drives digit k mod NUM_DIGITS, so the order is 0, 1, 2, 3, 0, and so on. Digit i sits at `digits_in[4i+3:4i]` and is strobed on `strobe_out[i]`.
- R6: The first PRESCALE clocks of every slot are dark: `strobe_out` and `seg_out` are both zero. For the rest of the slot exactly one strobe is high.
- R7: `seg_out` bit 0 is segment a and bit 6 is segment g. The hex patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R8: A digit value from 10 to 15 drives `seg_out` to zero while its strobe is high.
- R9: While `rst` is high the outputs are zero. Reset clears the held copy to all zeros and starts the scan in the dark phase before digit 0.
- R10: The scan timing depends only on the clocks counted since reset. Changes on `digits_in`, `latch_en` and `show_live` never move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the scan timebase is derived from it |
| rst | input | 1 | Asynchronous reset, active high |
| digits_in | input | 4*NUM_DIGITS | Live BCD digits; digit i at bits 4i+3:4i |
| latch_en | input | 1 | High: the held copy follows the live digits; low: it holds |
| show_live | input | 1 | High: show live digits; low: show held copy |
| seg_out | output | 7 | Segment lines a..g on bits 0..6, active high |
| strobe_out | output | NUM_DIGITS | Digit strobes, active high, at most one high |

## Verification
The assertions check on every cycle that at most one strobe is high and that segments are dark whenever no strobe is high. They also check that the scan position moves only at the end of a slot, that the held copy stays frozen with latch enable low and tracks the live digits with it high, and that a non-BCD digit never lights a segment. The exact segment patterns, the slot lengths and scan order, the reset contents of the held copy, and the choice between live and held digits are shown only by the bench's scenarios. The bench compares every cycle against a model that counts clocks from reset.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

   localparam int BCD_W = 4;
   localparam int SEG_W = 7;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // Segment a on bit 0 through g on bit 6; non-decimal codes stay dark.
   function automatic seg_t bcd_to_seg(input bcd_t v);
      seg_t s;
      unique case (v)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
   parameter int PRESCALE    = 4,
   parameter int DWELL_TICKS = 3,
   parameter int NUM_DIGITS  = 4,
   localparam int POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [POS_W-1:0] pos_o,
   output logic             dark_o
);

   localparam int SLOT_TICKS = DWELL_TICKS + 1;
   localparam int SLOT_W     = $clog2(SLOT_TICKS);
   localparam int PRE_W      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("scan_timer: PRESCALE must be at least 1");
   end
   if (DWELL_TICKS < 1) begin : g_bad_dwell
      $error("scan_timer: DWELL_TICKS must be at least 1");
   end
   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("scan_timer: NUM_DIGITS must be at least 2");
   end

   logic              tick;
   logic [SLOT_W-1:0] slot_q;
   logic [POS_W-1:0]  pos_q;

   // Prescaler variant chosen by parameter.
   if (PRESCALE == 1) begin : g_no_pre
      assign tick = 1'b1;
   end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            pre_q <= '0;
         end else if (pre_q == PRE_W'(PRESCALE - 1)) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));

      assert_pre_bound_R5: assert property (@(posedge clk) disable iff (rst)
         pre_q <= PRE_W'(PRESCALE - 1));
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         slot_q <= '0;
         pos_q  <= '0;
      end else if (tick) begin
         if (slot_q == SLOT_W'(SLOT_TICKS - 1)) begin
            slot_q <= '0;
            if (pos_q == POS_W'(NUM_DIGITS - 1)) begin
               pos_q <= '0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign pos_o  = pos_q;
   assign dark_o = (slot_q == '0);

   // Position only moves when a slot has run to its end.
   assert_pos_moves_at_slot_end_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(pos_q) |-> ($past(slot_q) == SLOT_W'(SLOT_TICKS - 1)));

   // A new position always opens with the dark phase.
   assert_new_digit_starts_dark_R6: assert property (@(posedge clk) disable iff (rst)
      !$stable(pos_q) |-> dark_o);

   assert_pos_in_range_R5: assert property (@(posedge clk) disable iff (rst)
      pos_q <= POS_W'(NUM_DIGITS - 1));

endmodule

// File: rtl/digit_hold.sv
module digit_hold
   import seg_scan_pkg::*;
#(
   parameter int NUM_DIGITS = 4,
   localparam int BUS_W = NUM_DIGITS * BCD_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [BUS_W-1:0] live_i,
   input  logic             follow_i,
   output logic [BUS_W-1:0] view_o
);

   logic [BUS_W-1:0] held_q;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            held_q[i*BCD_W +: BCD_W] <= '0;
         end else if (follow_i) begin
            held_q[i*BCD_W +: BCD_W] <= live_i[i*BCD_W +: BCD_W];
         end
      end
      // Transparent while following; stored copy otherwise.
      assign view_o[i*BCD_W +: BCD_W] = follow_i ? live_i[i*BCD_W +: BCD_W]
                                                 : held_q[i*BCD_W +: BCD_W];
   end

   assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (rst)
      !follow_i |=> $stable(held_q));

   assert_hold_tracks_R1: assert property (@(posedge clk) disable iff (rst)
      follow_i |=> (held_q == $past(live_i)));

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
   import seg_scan_pkg::*;
#(
   parameter int NUM_DIGITS  = 4,
   parameter int PRESCALE    = 4,
   parameter int DWELL_TICKS = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_in,
   input  logic                        latch_en,
   input  logic                        show_live,
   output logic [SEG_W-1:0]            seg_out,
   output logic [NUM_DIGITS-1:0]       strobe_out
);

   localparam int BUS_W = NUM_DIGITS * BCD_W;
   localparam int POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

   logic [POS_W-1:0] pos;
   logic             dark;
   logic [BUS_W-1:0] held_view;
   logic [BUS_W-1:0] source;
   bcd_t             cur_digit;
   bcd_t             digit_arr [NUM_DIGITS];

   scan_timer #(
      .PRESCALE   (PRESCALE),
      .DWELL_TICKS(DWELL_TICKS),
      .NUM_DIGITS (NUM_DIGITS)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .pos_o (pos),
      .dark_o(dark)
   );

   digit_hold #(
      .NUM_DIGITS(NUM_DIGITS)
   ) u_hold (
      .clk     (clk),
      .rst     (rst),
      .live_i  (digits_in),
      .follow_i(latch_en),
      .view_o  (held_view)
   );

   assign source = show_live ? digits_in : held_view;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_lane
      assign digit_arr[i]  = source[i*BCD_W +: BCD_W];
      assign strobe_out[i] = !dark && (pos == POS_W'(i));
   end

   assign cur_digit = digit_arr[pos];
   assign seg_out   = dark ? '0 : bcd_to_seg(cur_digit);

   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(strobe_out));

   assert_dark_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (strobe_out == '0) |-> (seg_out == '0));

   assert_nonbcd_unlit_R8: assert property (@(posedge clk) disable iff (rst)
      ((strobe_out != '0) && (cur_digit > 4'd9)) |-> (seg_out == '0));

endmodule

// File: tb/seg_scan_top_tb.sv
module seg_scan_top_tb;

   localparam int ND    = 4;
   localparam int PRE   = 4;
   localparam int DWELL = 3;
   localparam int SLOT  = DWELL + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [4*ND-1:0] digits = '0;
   logic          le = 1'b0;
   logic          sel = 1'b0;
   logic [6:0]    seg;
   logic [ND-1:0] strobe;

   int checks = 0;
   int errors = 0;
   int n_edges = 0;
   logic [4*ND-1:0] held_m = '0;
   string tag = "";
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   seg_scan_top #(.NUM_DIGITS(ND), .PRESCALE(PRE), .DWELL_TICKS(DWELL)) u_dut (
      .clk(clk), .rst(rst), .digits_in(digits), .latch_en(le),
      .show_live(sel), .seg_out(seg), .strobe_out(strobe)
   );

   // Bench model of time since reset and of the held copy.
   always @(posedge clk) begin
      if (rst) begin
         n_edges <= 0;
         held_m  <= '0;
      end else begin
         n_edges <= n_edges + 1;
         if (le) held_m <= digits;
      end
   end

   function automatic logic [6:0] ref_seg(input logic [3:0] v);
      case (v)
         4'd0: return 7'h3F;  4'd1: return 7'h06;
         4'd2: return 7'h5B;  4'd3: return 7'h4F;
         4'd4: return 7'h66;  4'd5: return 7'h6D;
         4'd6: return 7'h7D;  4'd7: return 7'h07;
         4'd8: return 7'h7F;  4'd9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at edge %0d", req, got, exp, n_edges);
      end
   endtask

   task automatic step();
      int ticks, s, pos;
      logic [4*ND-1:0] view;
      logic [3:0] nib;
      int exp_strobe, exp_seg;
      string rq;
      @(negedge clk);
      #1;
      ticks = n_edges / PRE;
      s     = ticks % SLOT;
      pos   = (ticks / SLOT) % ND;
      view  = sel ? digits : (le ? digits : held_m);
      nib   = view[pos*4 +: 4];
      exp_strobe = (s == 0) ? 0 : (1 << pos);
      exp_seg    = (s == 0) ? 0 : int'(ref_seg(nib));
      chk("R5 R10 strobe", int'(strobe), exp_strobe);
      chk("R4 onehot", ($countones(strobe) <= 1) ? 1 : 0, 1);
      if (s == 0) begin
         chk("R6 dark", int'(seg), 0);
      end else begin
         if (tag != "")       rq = tag;
         else if (nib > 9)    rq = "R8";
         else if (sel)        rq = "R3";
         else if (le)         rq = "R1";
         else                 rq = "R2";
         chk(rq, int'(seg), exp_seg);
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1987);
      repeat (3) @(negedge clk);
      #1;
      chk("R9 reset seg", int'(seg), 0);
      chk("R9 reset strobe", int'(strobe), 0);
      rst = 1'b0;

      // R9: held copy cleared, so held view shows zeros from digit 0.
      tag = "R9";
      digits = 16'h9876;
      repeat (ND * SLOT * PRE) begin
         step();
         digits = 16'(($urandom % 10) * 16'h1111);
      end

      // R7: every decimal pattern on the live path.
      tag = "R7";
      sel = 1'b1;
      for (int v = 0; v < 10; v++) begin
         digits = 16'(v * 16'h1111);
         repeat (ND * SLOT * PRE) step();
      end

      // R8: non-decimal codes stay dark.
      tag = "R8";
      for (int v = 10; v < 16; v++) begin
         digits = 16'(v * 16'h1111);
         repeat (ND * SLOT * PRE) step();
      end

      // R1: transparent held copy.
      tag = "R1";
      sel = 1'b0;
      le  = 1'b1;
      repeat (3 * ND * SLOT * PRE) begin
         digits = 16'($urandom);
         step();
      end

      // R2: frozen held copy while live digits churn.
      tag = "R2";
      digits = 16'h4321;
      step();
      le = 1'b0;
      repeat (3 * ND * SLOT * PRE) begin
         digits = 16'($urandom);
         step();
      end

      // Mixed random stimulus; tags picked per cycle (R3, R10 and others).
      tag = "";
      repeat (4000) begin
         if (($urandom % 8) == 0) le = ~le;
         if (($urandom % 4) == 0) sel = 1'($urandom);
         digits = 16'($urandom);
         step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule